// File: doc/BRIEF.md
# Digital Lock Detector with Hysteresis

This block decides whether a phase-locked loop has settled. It watches the divided reference pulse and the divided feedback pulse and measures, with a fast sampling clock, the number of sampling cycles between their rising edges. Each such measurement is one comparison.

The lock flag goes high only after a run of consecutive comparisons with a small error. The run length is chosen by a precision input. Once the flag is high, it drops only on a single comparison with a large error. The two thresholds differ, which gives the flag hysteresis. If the second edge of a pair never arrives, a timeout on the measuring counter closes the comparison and treats it as a large error.

Both pulse inputs are expected to be synchronous to the sampling clock.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `locked` is 0 and the count of consecutive small errors is zero. A reset that arrives partway through a run discards that run.
- R2: With `precise` at 0, `locked` rises after 3 consecutive comparisons whose error is strictly below `LOCK_CNT` (default 15). It does not rise after only 2.
- R3: With `precise` at 1, `locked` needs 5 such consecutive comparisons. It does not rise after 4.
- R4: The error of a comparison is the number of sampling-clock edges from the first rising edge to the other rising edge, with either pulse leading. Edges that are seen on the same clock edge give an error of 0.
- R5: While locked, a comparison with error strictly above `UNLOCK_CNT` (default 25) clears `locked`. The run count restarts from zero.
- R6: An error in the range `LOCK_CNT` to `UNLOCK_CNT` inclusive has no effect while locked. While unlocked, it restarts the run count from zero.
- R7: If the second edge has not arrived within `TIMEOUT_CNT` (default 100) sampling cycles of the first, the comparison ends as a large error. It clears `locked` and the run count.
- R8: `locked` changes only in the cycle after a comparison result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | Reference-divider output pulse |
| fb_pulse | input | 1 | Feedback-divider output pulse |
| precise | input | 1 | 0: three good comparisons lock; 1: five are needed |
| locked | output | 1 | Active-high lock flag |

## Verification
The bench drives errors exactly at the boundaries: one below the lock threshold, equal to it, equal to the unlock threshold, and one above it. A design with an off-by-one comparison would lock or unlock one step early. The bench stops one comparison short of the run length for both settings of `precise`. This catches a run counter that fires early or ignores the precision input. A medium error in the middle of a run must force the run to start again, and a medium error while locked must be ignored; a design that confused the two cases would lock too soon or drop lock wrongly. The bench also covers missing second edges, feedback-leading order, coincident edges, and a reset partway through a run. These catch a meter that hangs, that measures only one edge order, or that keeps a stale run.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [1:0] {
    ERR_SMALL = 2'd0,
    ERR_MID   = 2'd1,
    ERR_LARGE = 2'd2
  } err_class_e;

  // Map one measured error onto its hysteresis band.
  function automatic err_class_e classify(input int unsigned err, input logic tmo,
                                          input int unsigned lock_cnt,
                                          input int unsigned unlock_cnt);
    if (tmo || err > unlock_cnt) return ERR_LARGE;
    if (err < lock_cnt)          return ERR_SMALL;
    return ERR_MID;
  endfunction

  // Number of consecutive small errors needed before lock.
  function automatic int unsigned run_needed(input logic precise,
                                             input int unsigned run_lo,
                                             input int unsigned run_hi);
    return precise ? run_hi : run_lo;
  endfunction

endpackage

// File: rtl/pulse_rise.sv
module pulse_rise #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] level,
  output logic [LINES-1:0] rise
);
  logic [LINES-1:0] prev;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) prev[i] <= 1'b1;
        else        prev[i] <= level[i];
      end
      assign rise[i] = level[i] & ~prev[i];
    end
  endgenerate
endmodule

// File: rtl/phase_error_meter.sv
module phase_error_meter #(
  parameter int unsigned TIMEOUT_CNT = 100,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_err,
  output logic             meas_tmo
);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_CNT);

  logic             busy;
  logic             lead_ref;
  logic [CNT_W-1:0] cnt;
  logic             lag_rise;

  assign lag_rise = lead_ref ? fb_rise : ref_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      lead_ref   <= 1'b0;
      cnt        <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
      meas_tmo   <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (!busy) begin
        if (ref_rise && fb_rise) begin
          meas_valid <= 1'b1;
          meas_err   <= '0;
          meas_tmo   <= 1'b0;
        end else if (ref_rise || fb_rise) begin
          busy     <= 1'b1;
          lead_ref <= ref_rise;
          cnt      <= CNT_W'(1);
        end
      end else if (lag_rise) begin
        busy       <= 1'b0;
        meas_valid <= 1'b1;
        meas_err   <= cnt;
        meas_tmo   <= 1'b0;
      end else if (cnt == CNT_LIMIT) begin
        busy       <= 1'b0;
        meas_valid <= 1'b1;
        meas_err   <= cnt;
        meas_tmo   <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CNT_W'(1) && cnt <= CNT_LIMIT)); // R7
  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> meas_err <= CNT_LIMIT); // R4
  AST_TMO_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && meas_tmo) |-> $past(busy && !lag_rise)); // R7
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import lockdet_pkg::*;
#(
  parameter int unsigned LOCK_CNT   = 15,
  parameter int unsigned UNLOCK_CNT = 25,
  parameter int unsigned RUN_LO     = 3,
  parameter int unsigned RUN_HI     = 5,
  parameter int unsigned ERR_W      = 7,
  localparam int unsigned RUN_W     = $clog2(RUN_HI + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             precise,
  input  logic             meas_valid,
  input  logic [ERR_W-1:0] meas_err,
  input  logic             meas_tmo,
  output logic             locked
);
  err_class_e       cls;
  logic             is_small, is_mid, is_large;
  logic [RUN_W-1:0] run;
  logic             run_done;

  assign cls      = classify(int'(meas_err), meas_tmo, LOCK_CNT, UNLOCK_CNT);
  assign is_small = (cls == ERR_SMALL);
  assign is_mid   = (cls == ERR_MID);
  assign is_large = (cls == ERR_LARGE);
  assign run_done = (int'(run) + 1) >= int'(run_needed(precise, RUN_LO, RUN_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (meas_valid) begin
      if (is_large) begin
        locked <= 1'b0;
        run    <= '0;
      end else if (!locked) begin
        if (is_mid) begin
          run <= '0;
        end else if (run_done) begin
          locked <= 1'b1;
          run    <= '0;
        end else begin
          run <= run + RUN_W'(1);
        end
      end
    end
  end

  AST_DROP_ON_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && is_large) |=> !locked); // R5
  AST_MID_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && is_mid && locked) |=> locked); // R6
  AST_RISE_ON_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_valid && is_small)); // R2
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(locked)); // R8
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run) < int'(RUN_HI)); // R3
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int unsigned LOCK_CNT    = 15,
  parameter int unsigned UNLOCK_CNT  = 25,
  parameter int unsigned TIMEOUT_CNT = 100,
  parameter int unsigned RUN_LO      = 3,
  parameter int unsigned RUN_HI      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic precise,
  output logic locked
);
  localparam int unsigned ERR_W = $clog2(TIMEOUT_CNT + 1);

  logic [1:0]       rise;
  logic             meas_valid;
  logic [ERR_W-1:0] meas_err;
  logic             meas_tmo;

  pulse_rise #(.LINES(2)) u_rise (
    .clk(clk), .rst_n(rst_n), .level({fb_pulse, ref_pulse}), .rise(rise)
  );

  phase_error_meter #(.TIMEOUT_CNT(TIMEOUT_CNT)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_rise(rise[0]), .fb_rise(rise[1]),
    .meas_valid(meas_valid), .meas_err(meas_err), .meas_tmo(meas_tmo)
  );

  lock_qualifier #(
    .LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT),
    .RUN_LO(RUN_LO), .RUN_HI(RUN_HI), .ERR_W(ERR_W)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .precise(precise), .meas_valid(meas_valid),
    .meas_err(meas_err), .meas_tmo(meas_tmo), .locked(locked)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !locked); // R1
endmodule

// File: tb/phase_lock_monitor_test.sv
module phase_lock_monitor_test;
  localparam int LOCK = 15, UNLOCK = 25, TMO = 100;

  logic clk = 0, rst_n = 0, ref_p = 0, fb_p = 0, precise = 0;
  wire  locked;
  int   checks = 0, errors = 0;
  bit   m_locked = 0;
  int   m_run = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  phase_lock_monitor #(.LOCK_CNT(LOCK), .UNLOCK_CNT(UNLOCK), .TIMEOUT_CNT(TMO),
    .RUN_LO(3), .RUN_HI(5)) uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_p), .fb_pulse(fb_p),
    .precise(precise), .locked(locked));

  // 0 small, 1 mid, 2 large
  function automatic int band(input int d);
    if (d > TMO || d > UNLOCK) return 2;
    if (d < LOCK) return 0;
    return 1;
  endfunction

  function automatic int need(input bit p);
    return p ? 5 : 3;
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (locked !== exp) begin
      errors++;
      $display("FAIL %s: locked=%0b expected %0b", req, locked, exp);
    end
  endtask

  task automatic model_step(input int d);
    int b = band(d);
    if (b == 2) begin m_locked = 0; m_run = 0; end
    else if (!m_locked) begin
      if (b == 1) m_run = 0;
      else if (m_run + 1 >= need(precise)) begin m_locked = 1; m_run = 0; end
      else m_run++;
    end
  endtask

  // One comparison: lead edge, lag edge d cycles later (d > TMO: lag missing)
  task automatic compare(input bit lead_ref, input int d, input string req);
    @(negedge clk);
    if (d == 0) begin
      ref_p = 1; fb_p = 1; @(negedge clk); ref_p = 0; fb_p = 0;
    end else begin
      if (lead_ref) ref_p = 1; else fb_p = 1;
      @(negedge clk);
      ref_p = 0; fb_p = 0;
      if (d > TMO) repeat (TMO + 3) @(negedge clk);
      else begin
        repeat (d - 1) @(negedge clk);
        if (lead_ref) fb_p = 1; else ref_p = 1;
        @(negedge clk);
        ref_p = 0; fb_p = 0;
      end
    end
    repeat (4) @(negedge clk);
    model_step(d);
    check(req, m_locked);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1;
    m_locked = 0; m_run = 0;
    @(negedge clk);
    check("R1", 1'b0);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R2: three small errors with precise low
    precise = 0;
    compare(1, 3, "R2"); compare(1, 14, "R2"); compare(0, 14, "R2");
    // R6: mid errors at both band edges while locked
    compare(1, 15, "R6"); compare(0, 25, "R6");
    // R5: one step above unlock threshold
    compare(1, 26, "R5");
    // R3: five small errors needed with precise high
    precise = 1;
    compare(1, 1, "R3"); compare(1, 2, "R3"); compare(0, 0, "R4");
    compare(0, 7, "R3"); compare(1, 14, "R3");
    // R7: missing lagging edge
    compare(1, TMO + 1, "R7");
    // R6: mid error restarts run while unlocked
    compare(1, 4, "R6"); compare(1, 4, "R6"); compare(1, 15, "R6");
    compare(1, 4, "R6"); compare(0, 4, "R6"); compare(0, 4, "R6");
    compare(0, 4, "R6"); compare(0, 4, "R6");
    // R4: feedback leading, and a long but measured error
    compare(0, TMO, "R4");
    // R1: reset partway through a run
    precise = 0;
    compare(1, 2, "R1"); compare(1, 2, "R1");
    do_reset();
    compare(1, 2, "R1"); compare(1, 2, "R2"); compare(1, 2, "R2");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel = $urandom % 10;
      int d;
      if (sel < 6)      d = $urandom % LOCK;
      else if (sel < 8) d = LOCK + ($urandom % (UNLOCK - LOCK + 1));
      else if (sel < 9) d = UNLOCK + 1 + ($urandom % 20);
      else              d = (($urandom % 4) == 0) ? TMO + 1 : $urandom % 60;
      if (($urandom % 16) == 0) precise = ~precise;
      compare($urandom % 2, d, "R4");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: locked=%0b expected run to end", locked);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule